// File: doc/BRIEF.md
# Programmable Shift Unit with Automatic Push and Pull

This block holds the two data shift registers of a small programmable I/O sequencer. An input register gathers bits from operations that shift data in. An output register supplies bits to operations that shift data out. Each register has its own shift direction and a saturating count of the bits shifted since it was last emptied or refilled. A programmable threshold is set for each register, and a threshold field of 0 stands for a full 32-bit word. When the threshold is reached, the unit can move the input word into a receive queue and refill the output word from a transmit queue without being told to. Explicit push, conditional push and pull operations are also provided.

An instruction decoder presents one operation per cycle on `op_valid`/`op_kind`. The results of that operation (shifted-out bits, queue handshakes and stall) appear combinationally in the same cycle. Register state updates on the next rising clock edge. If an operation cannot finish because the receive queue is full or the transmit queue is empty, `stall` is raised and no state changes. The decoder holds the operation until it completes. Configuration is loaded through `cfg_we` and is held in a register with reset defaults.

Top module: `shift_unit`

## Requirements
- R1: After reset, both registers shift right, automatic push and pull are off, and both thresholds are 32. The input register is zero with count 0, and the output register is zero with count 32, so it is treated as empty.
- R2: With the input direction set to right (1), shifting in n bits moves the register right by n. The low n bits of `op_din` enter at the most significant end, with `op_din` bit 0 landing at bit 32-n. An `op_bits` value of 0 means 32.
- R3: With the input direction set to left (0), shifting in n bits moves the register left by n, and the low n bits of `op_din` enter at the least significant end.
- R4: With the output direction set to right (1), shifting out n bits emits the n least significant bits of the register in the low bits of `out_data`, with zeros above them. `out_valid` is raised, and the register then moves right by n.
- R5: With the output direction set to left (0), shifting out n bits emits the n most significant bits of the register, right-aligned in `out_data`. The register then moves left by n.
- R6: With automatic push on, a shift-in whose new count reaches or exceeds the push threshold (field 0 means 32) raises `rx_valid` in the same cycle, carrying the shifted word. On the handshake, the input register and its count return to 0.
- R7: An explicit push (`op_kind` 3) presents the input register on `rx_data` with `rx_valid`. On the handshake, the register and its count are cleared.
- R8: A conditional push (`op_kind` 4) behaves as R7 only when the input count is at or above the push threshold. Otherwise it completes at once, with no `rx_valid` and with the register and count unchanged.
- R9: A pull (`op_kind` 5) raises `tx_ready`. On the handshake it loads `tx_data` into the output register and sets the output count to 0.
- R10: With automatic pull on, a shift-out issued while the output count is at or above the pull threshold raises `tx_ready`. In that same cycle it shifts the bits from `tx_data` (count restarting at 0), not from the old register contents.
- R11: A push or shift-in that needs `rx_ready` while it is low, and a pull or refilling shift-out that needs `tx_valid` while it is low, raise `stall`. `out_valid` stays low and no register or count changes. The operation completes in the first cycle in which its handshake is met.
- R12: Both shift counts saturate at 32 and never wrap.
- R13: Operation encodings are: 0 = none, 1 = shift in, 2 = shift out, 3 = push, 4 = conditional push, 5 = pull. Codes 6 and 7 act as none. A configuration write takes effect from the following cycle and does not alter register contents or counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration fields below |
| cfg_in_right | input | 1 | Input register direction: 1 right, 0 left |
| cfg_out_right | input | 1 | Output register direction: 1 right, 0 left |
| cfg_autopush | input | 1 | Enable automatic push |
| cfg_autopull | input | 1 | Enable automatic pull |
| cfg_push_th | input | 5 | Push threshold, 0 means 32 |
| cfg_pull_th | input | 5 | Pull threshold, 0 means 32 |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation code (R13) |
| op_bits | input | 5 | Bit count for shifts, 0 means 32 |
| op_din | input | 32 | Source bits for a shift-in |
| stall | output | 1 | Operation cannot finish this cycle |
| out_valid | output | 1 | A shift-out completed this cycle |
| out_data | output | 32 | Shifted-out bits, right-aligned |
| rx_valid | output | 1 | Receive queue write request |
| rx_ready | input | 1 | Receive queue can accept |
| rx_data | output | 32 | Word pushed to the receive queue |
| tx_valid | input | 1 | Transmit queue has a word |
| tx_ready | output | 1 | Transmit queue read request |
| tx_data | input | 32 | Word from the transmit queue |

## Verification
Every result of an operation (`stall`, `out_valid`, `out_data`, `rx_valid`, `rx_data`, `tx_ready`) is due combinationally in the cycle the operation is presented. The register and count updates become visible only through the next operation, after one rising edge. The bench drives each operation just after a falling edge and compares the outputs one time unit later, well before the rising edge that commits state. It advances its model only across that edge, and only if it predicted no stall. Hidden state is brought out by a later push or shift-out, so contents, counts and threshold behaviour are always observed at the ports.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    localparam int SU_DATA_W = 32;
    localparam int SU_CNT_W  = $clog2(SU_DATA_W + 1);
    localparam int SU_TH_W   = $clog2(SU_DATA_W);

    typedef logic [SU_DATA_W-1:0] word_t;
    typedef logic [SU_CNT_W-1:0]  cnt_t;
    typedef logic [SU_TH_W-1:0]   fld_t;

    typedef enum logic [2:0] {
        OP_NONE        = 3'd0,
        OP_SHIFT_IN    = 3'd1,
        OP_SHIFT_OUT   = 3'd2,
        OP_PUSH        = 3'd3,
        OP_PUSH_IFFULL = 3'd4,
        OP_PULL        = 3'd5
    } op_kind_e;

    typedef struct packed {
        logic in_right;
        logic out_right;
        logic autopush;
        logic autopull;
        fld_t push_th;
        fld_t pull_th;
    } su_cfg_t;

    localparam su_cfg_t SU_CFG_RESET = '{
        in_right:  1'b1,
        out_right: 1'b1,
        autopush:  1'b0,
        autopull:  1'b0,
        push_th:   '0,
        pull_th:   '0
    };

    localparam cnt_t SU_FULL = cnt_t'(SU_DATA_W);

    // A field of zero stands for a whole word.
    function automatic cnt_t field_to_count(input fld_t f);
        return (f == '0) ? SU_FULL : cnt_t'(f);
    endfunction

    // Ones in the n least significant positions; n equal to the width gives all ones.
    function automatic word_t low_mask(input cnt_t n);
        return ~({SU_DATA_W{1'b1}} << n);
    endfunction

    function automatic cnt_t sat_add(input cnt_t a, input cnt_t b);
        logic [SU_CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s > (SU_CNT_W+1)'(SU_DATA_W)) ? SU_FULL : s[SU_CNT_W-1:0];
    endfunction

endpackage

// File: rtl/shift_unit_cfg.sv
module shift_unit_cfg
    import shift_unit_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  su_cfg_t cfg_d,
    output su_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= SU_CFG_RESET;
        else if (we)
            cfg_q <= cfg_d;
    end

    AST_CFG_RESET: assert property (@(posedge clk) rst |=> (cfg_q == SU_CFG_RESET)) else $error("cfg reset"); // R1

endmodule

// File: rtl/shift_unit_inreg.sv
module shift_unit_inreg
    import shift_unit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  push_req,
    input  logic  pushif_req,
    input  fld_t  bits,
    input  word_t din,
    input  logic  dir_right,
    input  logic  autopush,
    input  fld_t  push_th,
    input  logic  rx_ready,
    output logic  rx_valid,
    output word_t rx_data,
    output logic  done
);

    word_t acc_q;
    cnt_t  cnt_q;

    cnt_t  nb;
    cnt_t  thr;
    cnt_t  cnt_next;
    word_t din_m;
    word_t shifted;
    logic  hit;
    logic  full;
    logic  fire;

    always_comb begin
        nb       = field_to_count(bits);
        thr      = field_to_count(push_th);
        din_m    = din & low_mask(nb);
        if (dir_right)
            shifted = (acc_q >> nb) | (din_m << (SU_FULL - nb));
        else
            shifted = (acc_q << nb) | din_m;
        cnt_next = sat_add(cnt_q, nb);
        hit      = autopush && (cnt_next >= thr);
        full     = (cnt_q >= thr);
        rx_valid = (shift_en && hit) || push_req || (pushif_req && full);
        rx_data  = shift_en ? shifted : acc_q;
        fire     = rx_valid && rx_ready;
        done     = (shift_en || push_req || pushif_req) && (!rx_valid || rx_ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (fire) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (shift_en && !hit) begin
            acc_q <= shifted;
            cnt_q <= cnt_next;
        end
    end

    AST_IN_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt_q <= SU_FULL) else $error("in count"); // R12
    AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (rst) fire |=> (cnt_q == '0 && acc_q == '0)) else $error("push clear"); // R7
    AST_IN_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst) (rx_valid && !rx_ready) |=> ($stable(acc_q) && $stable(cnt_q))) else $error("in stall"); // R11
    AST_PUSHIF_IDLE: assert property (@(posedge clk) disable iff (rst) (pushif_req && !full) |=> $stable(acc_q)) else $error("pushif"); // R8
    AST_IN_RESET: assert property (@(posedge clk) rst |=> (cnt_q == '0 && acc_q == '0)) else $error("in reset"); // R1

endmodule

// File: rtl/shift_unit_outreg.sv
module shift_unit_outreg
    import shift_unit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  pull_req,
    input  fld_t  bits,
    input  logic  dir_right,
    input  logic  autopull,
    input  fld_t  pull_th,
    input  logic  tx_valid,
    input  word_t tx_data,
    output logic  tx_ready,
    output word_t out_data,
    output logic  out_valid,
    output logic  done
);

    word_t sh_q;
    cnt_t  cnt_q;

    cnt_t  nb;
    cnt_t  thr;
    cnt_t  base;
    logic  empty;
    logic  refill;
    word_t src;
    word_t rest;

    always_comb begin
        nb     = field_to_count(bits);
        thr    = field_to_count(pull_th);
        empty  = autopull && (cnt_q >= thr);
        refill = shift_en && empty;
        src    = refill ? tx_data : sh_q;
        base   = refill ? '0 : cnt_q;
        if (dir_right) begin
            out_data = src & low_mask(nb);
            rest     = src >> nb;
        end else begin
            out_data = src >> (SU_FULL - nb);
            rest     = src << nb;
        end
        tx_ready  = pull_req || refill;
        done      = (shift_en || pull_req) && (!tx_ready || tx_valid);
        out_valid = shift_en && done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= SU_FULL;
        end else if (pull_req && tx_valid) begin
            sh_q  <= tx_data;
            cnt_q <= '0;
        end else if (out_valid) begin
            sh_q  <= rest;
            cnt_q <= sat_add(base, nb);
        end
    end

    AST_OUT_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt_q <= SU_FULL) else $error("out count"); // R12
    AST_PULL_ZERO: assert property (@(posedge clk) disable iff (rst) (pull_req && tx_valid) |=> (cnt_q == '0)) else $error("pull count"); // R9
    AST_OUT_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst) (tx_ready && !tx_valid) |=> ($stable(sh_q) && $stable(cnt_q))) else $error("out stall"); // R11
    AST_OUT_RESET: assert property (@(posedge clk) rst |=> (cnt_q == SU_FULL && sh_q == '0)) else $error("out reset"); // R1

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_in_right,
    input  logic        cfg_out_right,
    input  logic        cfg_autopush,
    input  logic        cfg_autopull,
    input  logic [4:0]  cfg_push_th,
    input  logic [4:0]  cfg_pull_th,
    input  logic        op_valid,
    input  logic [2:0]  op_kind,
    input  logic [4:0]  op_bits,
    input  logic [31:0] op_din,
    output logic        stall,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic [31:0] rx_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    input  logic [31:0] tx_data
);

    su_cfg_t  cfg_d;
    su_cfg_t  cfg;
    op_kind_e kind;
    logic     is_in, is_out, is_push, is_pushif, is_pull, is_active;
    logic     in_done, out_done;

    always_comb begin
        cfg_d = '{
            in_right:  cfg_in_right,
            out_right: cfg_out_right,
            autopush:  cfg_autopush,
            autopull:  cfg_autopull,
            push_th:   cfg_push_th,
            pull_th:   cfg_pull_th
        };
        kind      = op_kind_e'(op_kind);
        is_in     = op_valid && (kind == OP_SHIFT_IN);
        is_out    = op_valid && (kind == OP_SHIFT_OUT);
        is_push   = op_valid && (kind == OP_PUSH);
        is_pushif = op_valid && (kind == OP_PUSH_IFFULL);
        is_pull   = op_valid && (kind == OP_PULL);
        is_active = is_in || is_out || is_push || is_pushif || is_pull;
        stall     = is_active && !(in_done || out_done);
    end

    shift_unit_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .cfg_d (cfg_d),
        .cfg_q (cfg)
    );

    shift_unit_inreg u_in (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (is_in),
        .push_req   (is_push),
        .pushif_req (is_pushif),
        .bits       (op_bits),
        .din        (op_din),
        .dir_right  (cfg.in_right),
        .autopush   (cfg.autopush),
        .push_th    (cfg.push_th),
        .rx_ready   (rx_ready),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .done       (in_done)
    );

    shift_unit_outreg u_out (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (is_out),
        .pull_req  (is_pull),
        .bits      (op_bits),
        .dir_right (cfg.out_right),
        .autopull  (cfg.autopull),
        .pull_th   (cfg.pull_th),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .done      (out_done)
    );

    AST_STALL_NO_OUT: assert property (@(posedge clk) disable iff (rst) stall |-> !out_valid) else $error("stall out"); // R11
    AST_ONE_QUEUE: assert property (@(posedge clk) disable iff (rst) !(rx_valid && tx_ready)) else $error("both queues"); // R13
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !op_valid |-> (!rx_valid && !tx_ready && !stall && !out_valid)) else $error("idle"); // R13

endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we = 1'b0;
    logic        cfg_in_right = 1'b1, cfg_out_right = 1'b1, cfg_autopush = 1'b0, cfg_autopull = 1'b0;
    logic [4:0]  cfg_push_th = '0, cfg_pull_th = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [4:0]  op_bits = '0;
    logic [31:0] op_din = '0;
    logic        stall, out_valid, rx_valid, tx_ready;
    logic [31:0] out_data, rx_data;
    logic        rx_ready = 1'b0, tx_valid = 1'b0;
    logic [31:0] tx_data = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_in, m_out;
    int          m_icnt, m_ocnt;
    bit          m_inr, m_outr, m_ap, m_apl;
    int          m_pth, m_qth;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_unit u_shift_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_in_right(cfg_in_right), .cfg_out_right(cfg_out_right),
        .cfg_autopush(cfg_autopush), .cfg_autopull(cfg_autopull),
        .cfg_push_th(cfg_push_th), .cfg_pull_th(cfg_pull_th),
        .op_valid(op_valid), .op_kind(op_kind), .op_bits(op_bits), .op_din(op_din),
        .stall(stall), .out_valid(out_valid), .out_data(out_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    function automatic int dec(input int f);
        return (f == 0) ? 32 : f;
    endfunction

    function automatic int satv(input int v);
        return (v > 32) ? 32 : v;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_in = '0; m_out = '0; m_icnt = 0; m_ocnt = 32;
        m_inr = 1; m_outr = 1; m_ap = 0; m_apl = 0; m_pth = 32; m_qth = 32;
    endtask

    task automatic do_cfg(input bit inr, input bit outr, input bit ap, input bit apl, input int pth, input int qth);
        @(negedge clk);
        cfg_we = 1'b1; cfg_in_right = inr; cfg_out_right = outr;
        cfg_autopush = ap; cfg_autopull = apl;
        cfg_push_th = 5'(pth); cfg_pull_th = 5'(qth);
        @(posedge clk);
        #1 cfg_we = 1'b0;
        m_inr = inr; m_outr = outr; m_ap = ap; m_apl = apl;
        m_pth = dec(pth); m_qth = dec(qth);
    endtask

    // Presents one operation for one cycle and compares every output with the model.
    task automatic apply(input int kind, input int nbits, input logic [31:0] din,
                         input bit rxr, input bit txv, input logic [31:0] txd, input string req);
        int n;
        logic [31:0] e_rxd, e_out, nin, src;
        bit e_rxv, e_txr, e_outv, e_stall;
        int ncnt, base;
        @(negedge clk);
        op_valid = 1'b1; op_kind = 3'(kind); op_bits = 5'(nbits); op_din = din;
        rx_ready = rxr; tx_valid = txv; tx_data = txd;
        #1;
        n = dec(nbits);
        e_rxv = 0; e_txr = 0; e_outv = 0; e_stall = 0; e_rxd = m_in; e_out = '0;
        nin = m_in; ncnt = m_icnt; src = m_out; base = m_ocnt;
        case (kind)
            1: begin
                for (int i = 0; i < n; i++)
                    if (m_inr) nin = {din[i], nin[31:1]};
                for (int i = n - 1; i >= 0; i--)
                    if (!m_inr) nin = {nin[30:0], din[i]};
                ncnt = satv(m_icnt + n);
                e_rxd = nin;
                e_rxv = m_ap && (ncnt >= m_pth);
                e_stall = e_rxv && !rxr;
            end
            2: begin
                if (m_apl && m_ocnt >= m_qth) begin
                    e_txr = 1; src = txd; base = 0; e_stall = !txv;
                end
                e_outv = !e_stall;
                for (int i = 0; i < n; i++) begin
                    if (m_outr) begin
                        e_out[i] = src[0]; src = {1'b0, src[31:1]};
                    end else begin
                        e_out = {e_out[30:0], src[31]}; src = {src[30:0], 1'b0};
                    end
                end
            end
            3: begin e_rxv = 1; e_stall = !rxr; end
            4: begin e_rxv = (m_icnt >= m_pth); e_stall = e_rxv && !rxr; end
            5: begin e_txr = 1; e_stall = !txv; end
            default: ;
        endcase
        chk(req, "stall", 32'(stall), 32'(e_stall));
        chk(req, "rx_valid", 32'(rx_valid), 32'(e_rxv));
        if (e_rxv) chk(req, "rx_data", rx_data, e_rxd);
        chk(req, "tx_ready", 32'(tx_ready), 32'(e_txr));
        chk(req, "out_valid", 32'(out_valid), 32'(e_outv));
        if (e_outv) chk(req, "out_data", out_data, e_out);
        @(posedge clk);
        #1 op_valid = 1'b0;
        if (!e_stall) begin
            case (kind)
                1: if (e_rxv) begin m_in = '0; m_icnt = 0; end
                   else begin m_in = nin; m_icnt = ncnt; end
                2: begin m_out = src; m_ocnt = satv(base + n); end
                3, 4: if (e_rxv) begin m_in = '0; m_icnt = 0; end
                5: begin m_out = txd; m_ocnt = 0; end
                default: ;
            endcase
        end
    endtask

    task automatic t_reset();
        do_reset();
        apply(3, 0, '0, 1, 0, '0, "R1");                 // empty input register
        apply(4, 0, '0, 1, 0, '0, "R1");                 // count 0 below default 32
        apply(2, 8, '0, 0, 1, 32'hFFFF_FFFF, "R1");      // autopull off: zeros, no refill
        apply(1, 8, 32'hA5, 1, 0, '0, "R1");             // default right shift
        apply(3, 0, '0, 1, 0, '0, "R1");
    endtask

    task automatic t_in_dirs();
        for (int d = 0; d < 2; d++) begin
            do_cfg(d[0], 1, 0, 0, 0, 0);
            apply(1, 5, 32'hFFFF_FF13, 1, 0, '0, d ? "R2" : "R3");
            apply(1, 1, 32'h1, 1, 0, '0, d ? "R2" : "R3");
            apply(1, 12, 32'h0000_0ABC, 1, 0, '0, d ? "R2" : "R3");
            apply(3, 0, '0, 1, 0, '0, d ? "R2" : "R3");
            apply(1, 7, 32'h55, 1, 0, '0, d ? "R2" : "R3");
            apply(1, 0, 32'hDEAD_BEEF, 1, 0, '0, d ? "R2" : "R3");
            apply(3, 0, '0, 1, 0, '0, d ? "R2" : "R3");
        end
    endtask

    task automatic t_out_dirs();
        for (int d = 0; d < 2; d++) begin
            do_cfg(1, d[0], 0, 0, 0, 0);
            apply(5, 0, '0, 0, 1, 32'h8421_F00D, "R9");
            apply(2, 4, '0, 0, 0, '0, d ? "R4" : "R5");
            apply(2, 1, '0, 0, 0, '0, d ? "R4" : "R5");
            apply(2, 11, '0, 0, 0, '0, d ? "R4" : "R5");
            apply(5, 0, '0, 0, 1, 32'hC3A5_0F96, "R9");
            apply(2, 0, '0, 0, 0, '0, d ? "R4" : "R5");
        end
    endtask

    task automatic t_autopush();
        int ths[4] = '{1, 8, 31, 0};
        for (int d = 0; d < 2; d++)
            for (int t = 0; t < 4; t++) begin
                do_cfg(d[0], 1, 1, 0, ths[t], 0);
                apply(1, 3, 32'h5, 1, 0, '0, "R6");
                apply(1, 6, 32'h2D, 1, 0, '0, "R6");
                apply(1, 30, 32'h1234_5678, 1, 0, '0, "R6");
                apply(1, 0, 32'h9ABC_DEF0, 1, 0, '0, "R6");
                apply(3, 0, '0, 1, 0, '0, "R6");
            end
    endtask

    task automatic t_pushif();
        do_cfg(1, 1, 0, 0, 8, 0);
        apply(1, 4, 32'hC, 1, 0, '0, "R8");
        apply(4, 0, '0, 1, 0, '0, "R8");                 // below threshold: nothing
        apply(1, 4, 32'h3, 1, 0, '0, "R8");
        apply(4, 0, '0, 1, 0, '0, "R8");                 // at threshold: pushes
        apply(3, 0, '0, 1, 0, '0, "R7");                 // cleared by the push
        apply(1, 9, 32'h1FF, 1, 0, '0, "R7");
        apply(3, 0, '0, 1, 0, '0, "R7");
        apply(6, 3, '0, 1, 1, '0, "R13");                // unused code is a no-op
        apply(7, 3, '0, 1, 1, '0, "R13");
    endtask

    task automatic t_autopull();
        int ths[4] = '{1, 8, 31, 0};
        for (int d = 0; d < 2; d++)
            for (int t = 0; t < 4; t++) begin
                do_reset();
                do_cfg(1, d[0], 0, 1, ths[t], ths[t]);
                apply(2, 8, '0, 0, 1, 32'hF0E1_D2C3, "R10");
                apply(2, 8, '0, 0, 1, 32'h1122_3344, "R10");
                apply(2, 23, '0, 0, 1, 32'h5566_7788, "R10");
                apply(2, 1, '0, 0, 1, 32'h99AA_BBCC, "R10");
                apply(5, 0, '0, 0, 1, 32'h0F0F_1234, "R9");
                apply(2, 0, '0, 0, 1, 32'hAAAA_5555, "R10");
            end
    endtask

    task automatic t_stall();
        do_reset();
        do_cfg(1, 1, 1, 1, 8, 8);
        apply(1, 4, 32'h9, 1, 0, '0, "R11");
        apply(3, 0, '0, 0, 0, '0, "R11");                // push blocked
        apply(1, 4, 32'h6, 0, 0, '0, "R11");             // autopush blocked
        apply(1, 4, 32'h6, 0, 0, '0, "R11");
        apply(1, 4, 32'h6, 1, 0, '0, "R11");             // completes
        apply(2, 4, '0, 0, 0, 32'hBEEF_0001, "R11");     // refill blocked
        apply(2, 4, '0, 0, 1, 32'hBEEF_0001, "R11");
        apply(5, 0, '0, 0, 0, 32'h1234_5678, "R11");     // pull blocked
        apply(5, 0, '0, 0, 1, 32'h1234_5678, "R11");
        apply(2, 8, '0, 0, 0, '0, "R11");
    endtask

    task automatic t_sat();
        do_reset();
        do_cfg(0, 0, 0, 0, 0, 0);
        apply(1, 0, 32'h1111_2222, 1, 0, '0, "R12");
        apply(1, 0, 32'h3333_4444, 1, 0, '0, "R12");
        apply(4, 0, '0, 1, 0, '0, "R12");                // saturated count still full
        apply(5, 0, '0, 0, 1, 32'h7654_3210, "R12");
        apply(2, 0, '0, 0, 0, '0, "R12");
        apply(2, 0, '0, 0, 0, '0, "R12");
        do_cfg(0, 0, 0, 1, 0, 0);                        // R13: counts survive config write
        apply(2, 8, '0, 0, 1, 32'hCAFE_F00D, "R12");     // still empty: refills
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_in_dirs();
        t_out_dirs();
        t_autopush();
        t_pushif();
        t_autopull();
        t_stall();
        t_sat();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule